// File: doc/BRIEF.md
# Pulse-and-Verify Word Programming Sequencer

This controller writes a contiguous range of 16-bit words into an external parallel ROM whose cells can only be moved from 1 to 0 by timed high-voltage pulses. For each address it first reads the current contents and compares them with the wanted word. A word that would need any bit raised from 0 to 1 is refused at once. A word that already matches is skipped. Any other word gets a series of fixed-width program pulses, each followed by a read-back, until the read-back matches or the pulse budget runs out.

Once the last address has been written, the whole range is read back twice: first with the core supply request at the high check level, then at the low check level. Every timing (supply settle, setup, hold, pulse width, read access) is a count of clock cycles set by a parameter. The block only requests supplies. The analog switching sits outside it. The target word for each address comes from a source that presents `src_data` for the address currently on `mem_addr`.

Top module: `romprog_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `ce_n`=1, `oe_n`=1, `bus_drive`=0, `hv_en`=0, `core_sel`=0, `busy`=0 and `done`=0.
- R2: `ce_n` is low only while `hv_en`=1 and `core_sel`=1 (program level). The first falling edge of `ce_n` in a run comes at least SUPPLY_CYC cycles after `hv_en` rises. `core_sel` codes are: 0 normal, 1 program, 2 high check, 3 low check.
- R3: Each program pulse holds `ce_n` low for exactly PULSE_CYC cycles with `oe_n` high. `mem_addr` and `wdata` stay stable during the pulse. `bus_drive` is high for at least SETUP_CYC cycles before the pulse and at least HOLD_CYC cycles after it.
- R4: `bus_drive` and a low `oe_n` never coincide, `bus_drive` is low in the cycle before `oe_n` falls, and `ce_n` is high whenever `oe_n` is low.
- R5: A programmable word that differs from its target gets pulses until the read-back equals the target. The number of pulses equals the number the cell needs. After MAX_PULSES pulses without a match, the run fails with `fail_addr` set to that word's address.
- R6: A word whose current contents already equal the target gets no pulse.
- R7: If the target has a 1 in any bit where the current contents hold 0, the run fails at once with `fail_addr` set to that address, and that word gets no pulse.
- R8: After the last word, every word in the range is read and compared with `core_sel`=2, then again with `core_sel`=3. A mismatch in either pass fails the run at that address.
- R9: The end of a run gives a one-cycle `done` with `hv_en`=0 and `core_sel`=0. `prog_ok` and `fail_addr` hold their values until the next start.
- R10: `start` is ignored while `busy` is high.
- R11: A start with `end_addr` below `start_addr` fails at once with `fail_addr`=`start_addr`, and `hv_en` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled when idle) |
| start_addr | input | AW | First address of the range |
| end_addr | input | AW | Last address of the range |
| src_data | input | DW | Target word for the address on `mem_addr` |
| rdata | input | DW | Data read from the ROM data bus |
| mem_addr | output | AW | ROM address bus |
| wdata | output | DW | Word driven onto the ROM data bus |
| bus_drive | output | 1 | Enable for driving `wdata` onto the data bus |
| ce_n | output | 1 | ROM chip enable, low during a program pulse |
| oe_n | output | 1 | ROM output enable, low during a read |
| hv_en | output | 1 | Request for the programming high voltage |
| core_sel | output | 2 | Core supply level request (0 normal, 1 program, 2 high check, 3 low check) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| prog_ok | output | 1 | Last run succeeded |
| fail_addr | output | AW | Address where the last run failed |

## Verification
The assertions watch the bus-level rules on every cycle. These cover pulse width, supply level during a pulse, data setup and hold around the pulse, address and data stability, the gap between releasing the bus and lowering `oe_n`, the per-word pulse budget, and idle supplies at `done`. Whether the right words were pulsed the right number of times can only be shown by the bench's scenarios, which run against a ROM model whose cells need a set number of pulses. The same goes for refusing a 0-to-1 word, skipping already-matching words, failing in the low-level check pass, reversed ranges, and ignoring a start while busy.

// File: rtl/romprog_pkg.sv
package romprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAMP,
        ST_RD_GAP,
        ST_RD_WAIT,
        ST_RD_END,
        ST_EVAL,
        ST_DSETUP,
        ST_PULSE,
        ST_PHOLD,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_PRE,
        PH_VERIFY,
        PH_CHECK
    } seq_phase_e;

    typedef enum logic [1:0] {
        LVL_NORMAL = 2'd0,
        LVL_PROG   = 2'd1,
        LVL_CHK_HI = 2'd2,
        LVL_CHK_LO = 2'd3
    } core_lvl_e;

    typedef struct packed {
        logic match;
        logic blocked;
    } cmp_res_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic core_lvl_e check_level(input logic second_pass);
        return second_pass ? LVL_CHK_LO : LVL_CHK_HI;
    endfunction

endpackage

// File: rtl/romprog_timer.sv
module romprog_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len == '0) ? '0 : len - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/romprog_cmp.sv
module romprog_cmp
    import romprog_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] rd_word,
    input  logic [DW-1:0] tgt_word,
    output cmp_res_t      res
);
    logic [DW-1:0] raise_bit;
    logic [DW-1:0] diff_bit;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign raise_bit[i] = tgt_word[i] & ~rd_word[i];
        assign diff_bit[i]  = tgt_word[i] ^ rd_word[i];
    end

    assign res.match   = ~|diff_bit;
    assign res.blocked = |raise_bit;
endmodule

// File: rtl/romprog_ctrl.sv
module romprog_ctrl
    import romprog_pkg::*;
#(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int TW         = 13,
    parameter int SUPPLY_CYC = 100,
    parameter int SETUP_CYC  = 100,
    parameter int HOLD_CYC   = 100,
    parameter int PULSE_CYC  = 5000,
    parameter int ACC_CYC    = 8,
    parameter int MAX_PULSES = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic [DW-1:0] src_data,
    input  logic [DW-1:0] rdata,
    input  logic          tmr_expired,
    input  cmp_res_t      cmp,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_len,
    output logic [DW-1:0] rd_q,
    output logic [DW-1:0] tgt_q,
    output logic [AW-1:0] mem_addr,
    output logic          bus_drive,
    output logic          ce_n,
    output logic          oe_n,
    output logic          hv_en,
    output logic [1:0]    core_sel,
    output logic          busy,
    output logic          done,
    output logic          prog_ok,
    output logic [AW-1:0] fail_addr
);
    localparam int PCW = $clog2(MAX_PULSES + 1);

    seq_state_e    state_q, nxt;
    seq_phase_e    phase_q;
    core_lvl_e     lvl_q;
    logic [AW-1:0] addr_q, first_q, last_q;
    logic [PCW-1:0] pcnt_q;
    logic          second_q;
    logic          ok_q;
    logic [AW-1:0] fail_q;

    logic at_end, in_eval, advance, fail_now, chk_good, bad_range;

    function automatic logic [TW-1:0] dur(input seq_state_e s);
        case (s)
            ST_RAMP:              return TW'(SUPPLY_CYC);
            ST_RD_GAP, ST_DSETUP: return TW'(SETUP_CYC);
            ST_RD_WAIT:           return TW'(ACC_CYC);
            ST_RD_END, ST_PHOLD:  return TW'(HOLD_CYC);
            ST_PULSE:             return TW'(PULSE_CYC);
            default:              return TW'(1);
        endcase
    endfunction

    always_comb begin
        at_end    = (addr_q == last_q);
        in_eval   = (state_q == ST_EVAL);
        bad_range = (end_addr < start_addr);
        advance   = in_eval && (phase_q != PH_CHECK) && cmp.match;
        chk_good  = in_eval && (phase_q == PH_CHECK) && cmp.match;
        fail_now  = in_eval &&
                    (((phase_q == PH_PRE) && cmp.blocked) ||
                     ((phase_q == PH_VERIFY) && !cmp.match && (pcnt_q == PCW'(MAX_PULSES))) ||
                     ((phase_q == PH_CHECK) && !cmp.match));
    end

    always_comb begin
        nxt = state_q;
        case (state_q)
            ST_IDLE:    if (start) nxt = bad_range ? ST_FINISH : ST_RAMP;
            ST_RAMP:    if (tmr_expired) nxt = ST_RD_GAP;
            ST_RD_GAP:  if (tmr_expired) nxt = ST_RD_WAIT;
            ST_RD_WAIT: if (tmr_expired) nxt = ST_RD_END;
            ST_RD_END:  if (tmr_expired) nxt = ST_EVAL;
            ST_EVAL: begin
                if (fail_now)       nxt = ST_FINISH;
                else if (advance)   nxt = at_end ? ST_RAMP : ST_RD_GAP;
                else if (chk_good)  nxt = at_end ? (second_q ? ST_FINISH : ST_RAMP) : ST_RD_GAP;
                else                nxt = ST_DSETUP;
            end
            ST_DSETUP:  if (tmr_expired) nxt = ST_PULSE;
            ST_PULSE:   if (tmr_expired) nxt = ST_PHOLD;
            ST_PHOLD:   if (tmr_expired) nxt = ST_RD_GAP;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        tmr_load = (nxt != state_q);
        tmr_len  = dur(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_PRE;
            lvl_q    <= LVL_NORMAL;
            addr_q   <= '0;
            first_q  <= '0;
            last_q   <= '0;
            pcnt_q   <= '0;
            second_q <= 1'b0;
            ok_q     <= 1'b0;
            fail_q   <= '0;
            rd_q     <= '0;
            tgt_q    <= '0;
        end else begin
            state_q <= nxt;
            if (state_q == ST_IDLE && start) begin
                first_q <= start_addr;
                last_q  <= end_addr;
                addr_q  <= start_addr;
                ok_q    <= 1'b0;
                fail_q  <= '0;
                if (bad_range) begin
                    fail_q <= start_addr;
                end else begin
                    lvl_q    <= LVL_PROG;
                    phase_q  <= PH_PRE;
                    second_q <= 1'b0;
                end
            end
            if (state_q == ST_RD_WAIT && tmr_expired) begin
                rd_q  <= rdata;
                tgt_q <= src_data;
            end
            if (state_q == ST_DSETUP && tmr_expired) begin
                pcnt_q <= pcnt_q + PCW'(1);
            end
            if (in_eval) begin
                if (fail_now) begin
                    fail_q <= addr_q;
                    lvl_q  <= LVL_NORMAL;
                end else if (advance) begin
                    if (at_end) begin
                        phase_q  <= PH_CHECK;
                        addr_q   <= first_q;
                        second_q <= 1'b0;
                        lvl_q    <= check_level(1'b0);
                    end else begin
                        phase_q <= PH_PRE;
                        addr_q  <= addr_q + AW'(1);
                    end
                end else if (chk_good) begin
                    if (at_end) begin
                        if (second_q) begin
                            ok_q  <= 1'b1;
                            lvl_q <= LVL_NORMAL;
                        end else begin
                            second_q <= 1'b1;
                            addr_q   <= first_q;
                            lvl_q    <= check_level(1'b1);
                        end
                    end else begin
                        addr_q <= addr_q + AW'(1);
                    end
                end else if (phase_q == PH_PRE) begin
                    pcnt_q  <= '0;
                    phase_q <= PH_VERIFY;
                end
            end
        end
    end

    assign mem_addr  = addr_q;
    assign bus_drive = (state_q == ST_DSETUP) || (state_q == ST_PULSE) || (state_q == ST_PHOLD);
    assign ce_n      = (state_q != ST_PULSE);
    assign oe_n      = (state_q != ST_RD_WAIT);
    assign hv_en     = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign core_sel  = lvl_q;
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign done      = (state_q == ST_FINISH);
    assign prog_ok   = ok_q;
    assign fail_addr = fail_q;
endmodule

// File: rtl/romprog_seq.sv
module romprog_seq
    import romprog_pkg::*;
#(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int SUPPLY_CYC = 100,
    parameter int SETUP_CYC  = 100,
    parameter int HOLD_CYC   = 100,
    parameter int PULSE_CYC  = 5000,
    parameter int ACC_CYC    = 8,
    parameter int MAX_PULSES = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic [DW-1:0] src_data,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] wdata,
    output logic          bus_drive,
    output logic          ce_n,
    output logic          oe_n,
    output logic          hv_en,
    output logic [1:0]    core_sel,
    output logic          busy,
    output logic          done,
    output logic          prog_ok,
    output logic [AW-1:0] fail_addr
);
    localparam int LONGEST = max2(max2(SUPPLY_CYC, SETUP_CYC),
                                  max2(max2(HOLD_CYC, PULSE_CYC), ACC_CYC));
    localparam int TW = $clog2(LONGEST + 1) + 1;

    logic          tmr_load;
    logic          tmr_expired;
    logic [TW-1:0] tmr_len;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] tgt_q;
    cmp_res_t      cmp;

    romprog_timer #(.CW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

    romprog_cmp #(.DW(DW)) u_cmp (
        .rd_word  (rd_q),
        .tgt_word (tgt_q),
        .res      (cmp)
    );

    romprog_ctrl #(
        .AW(AW), .DW(DW), .TW(TW),
        .SUPPLY_CYC(SUPPLY_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
        .PULSE_CYC(PULSE_CYC), .ACC_CYC(ACC_CYC), .MAX_PULSES(MAX_PULSES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_addr  (start_addr),
        .end_addr    (end_addr),
        .src_data    (src_data),
        .rdata       (rdata),
        .tmr_expired (tmr_expired),
        .cmp         (cmp),
        .tmr_load    (tmr_load),
        .tmr_len     (tmr_len),
        .rd_q        (rd_q),
        .tgt_q       (tgt_q),
        .mem_addr    (mem_addr),
        .bus_drive   (bus_drive),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .hv_en       (hv_en),
        .core_sel    (core_sel),
        .busy        (busy),
        .done        (done),
        .prog_ok     (prog_ok),
        .fail_addr   (fail_addr)
    );

    assign wdata = tgt_q;
endmodule

// File: rtl/romprog_chk.sv
module romprog_chk #(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int SUPPLY_CYC = 100,
    parameter int SETUP_CYC  = 100,
    parameter int HOLD_CYC   = 100,
    parameter int PULSE_CYC  = 5000,
    parameter int MAX_PULSES = 25
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] wdata,
    input logic          bus_drive,
    input logic          ce_n,
    input logic          oe_n,
    input logic          hv_en,
    input logic [1:0]    core_sel,
    input logic          busy,
    input logic          done
);
    logic [31:0]   low_len, drive_age, lvl_age, after_pulse, word_pulses;
    logic          ce_prev, hv_prev;
    logic [1:0]    lvl_prev;
    logic [AW-1:0] addr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_len     <= '0;
            drive_age   <= '0;
            lvl_age     <= '0;
            after_pulse <= '0;
            word_pulses <= '0;
            ce_prev     <= 1'b1;
            hv_prev     <= 1'b0;
            lvl_prev    <= 2'd0;
            addr_prev   <= '0;
        end else begin
            ce_prev   <= ce_n;
            hv_prev   <= hv_en;
            lvl_prev  <= core_sel;
            addr_prev <= mem_addr;
            low_len   <= ce_n ? '0 : ((low_len != '1) ? low_len + 32'd1 : low_len);
            drive_age <= !bus_drive ? '0 : ((drive_age != '1) ? drive_age + 32'd1 : drive_age);
            if (hv_en != hv_prev || core_sel != lvl_prev) lvl_age <= '0;
            else if (lvl_age != '1) lvl_age <= lvl_age + 32'd1;
            if (!ce_n) after_pulse <= '0;
            else if (bus_drive && after_pulse != '1) after_pulse <= after_pulse + 32'd1;
            if (mem_addr != addr_prev) word_pulses <= '0;
            else if (ce_prev && !ce_n) word_pulses <= word_pulses + 32'd1;
        end
    end

    assert_pulse_supply_R2: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> (hv_en && core_sel == 2'd1));

    assert_supply_settle_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_n) |-> (lvl_age >= 32'(SUPPLY_CYC)));

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n) |-> (low_len == 32'(PULSE_CYC)));

    assert_pulse_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> (oe_n && bus_drive && $stable(mem_addr) && $stable(wdata)));

    assert_data_setup_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_n) |-> (drive_age >= 32'(SETUP_CYC)));

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_drive) |-> (after_pulse >= 32'(HOLD_CYC)));

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_drive && !oe_n));

    assert_read_gap_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> ($past(!bus_drive) && ce_n));

    assert_pulse_budget_R5: assert property (@(posedge clk) disable iff (rst)
        (ce_prev && !ce_n) |-> (word_pulses < 32'(MAX_PULSES)));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!hv_en && core_sel == 2'd0 && !busy && ce_n && oe_n && !bus_drive));
endmodule

bind romprog_seq romprog_chk #(
    .AW(AW), .DW(DW), .SUPPLY_CYC(SUPPLY_CYC), .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .wdata     (wdata),
    .bus_drive (bus_drive),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .hv_en     (hv_en),
    .core_sel  (core_sel),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_romprog_seq.sv
module sim_romprog_seq;
    localparam int AW   = 4;
    localparam int DW   = 16;
    localparam int SUP  = 4;
    localparam int SET  = 3;
    localparam int HLD  = 2;
    localparam int PW   = 10;
    localparam int ACC  = 2;
    localparam int MAXP = 25;
    localparam int N    = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0, end_addr = '0;
    logic [DW-1:0] src_data, rdata, wdata;
    logic [AW-1:0] mem_addr, fail_addr;
    logic          bus_drive, ce_n, oe_n, hv_en, busy, done, prog_ok;
    logic [1:0]    core_sel;

    logic [DW-1:0] mem [N];
    logic [DW-1:0] mem0 [N];
    logic [DW-1:0] tgt [N];
    int            need [N];
    int            pulses [N];
    logic          drift [N];

    int n_chk = 0, n_err = 0;
    int low_w = 0, sup_age = 0, first_gap = 0, conflicts = 0, bad_pulse = 0;
    bit ce_prev = 1, hv_prev = 0, seen_fall = 0, saw_hi = 0, saw_lo = 0, hv_seen = 0;

    assign src_data = tgt[mem_addr];
    assign rdata = (!oe_n && ce_n)
                 ? ((drift[mem_addr] && core_sel == 2'd3) ? (mem[mem_addr] ^ 16'h0001) : mem[mem_addr])
                 : 16'hDEAD;

    romprog_seq #(
        .AW(AW), .DW(DW), .SUPPLY_CYC(SUP), .SETUP_CYC(SET), .HOLD_CYC(HLD),
        .PULSE_CYC(PW), .ACC_CYC(ACC), .MAX_PULSES(MAXP)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .end_addr(end_addr),
        .src_data(src_data), .rdata(rdata), .mem_addr(mem_addr), .wdata(wdata),
        .bus_drive(bus_drive), .ce_n(ce_n), .oe_n(oe_n), .hv_en(hv_en), .core_sel(core_sel),
        .busy(busy), .done(done), .prog_ok(prog_ok), .fail_addr(fail_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ROM model and bus monitor, sampled between clock edges
    always @(negedge clk) begin
        if (!rst) begin
            if (hv_en) hv_seen = 1;
            if (hv_en && !hv_prev) sup_age = 0;
            else if (hv_en) sup_age++;
            if (!ce_n) begin
                if (ce_prev && !seen_fall) begin
                    first_gap = sup_age;
                    seen_fall = 1;
                end
                if (core_sel != 2'd1 || !hv_en) bad_pulse++;
                low_w++;
            end
            if (ce_n && !ce_prev) begin
                chk(low_w == PW, "R3", "pulse width", 64'(low_w), 64'(PW));
                pulses[mem_addr]++;
                if (pulses[mem_addr] >= need[mem_addr]) mem[mem_addr] = mem[mem_addr] & wdata;
                low_w = 0;
            end
            if (bus_drive && !oe_n) conflicts++;
            if (core_sel == 2'd2) saw_hi = 1;
            if (core_sel == 2'd3) saw_lo = 1;
            ce_prev = ce_n;
            hv_prev = hv_en;
        end
    end

    task automatic clear_model();
        for (int a = 0; a < N; a++) begin
            mem[a] = 16'hFFFF; tgt[a] = 16'hFFFF; need[a] = 1; drift[a] = 0; pulses[a] = 0;
        end
    endtask

    function automatic int exp_pulses(input int a);
        if (mem0[a] == tgt[a]) return 0;
        return (need[a] > MAXP) ? MAXP : need[a];
    endfunction

    task automatic run(input int sa, input int ea, input int poke_at,
                       input bit exp_ok, input int exp_fa, input string req);
        int cyc;
        seen_fall = 0; saw_hi = 0; saw_lo = 0; conflicts = 0; bad_pulse = 0; hv_seen = 0;
        for (int a = 0; a < N; a++) begin pulses[a] = 0; mem0[a] = mem[a]; end
        @(negedge clk);
        start_addr = AW'(sa); end_addr = AW'(ea); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke_at != 0 && cyc == poke_at) begin
                start_addr = '0; end_addr = AW'(N - 1); start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (!done) begin
            chk(0, req, "watchdog expired", 64'(cyc), 64'd0);
            return;
        end
        chk(prog_ok == exp_ok, req, "run result", 64'(prog_ok), 64'(exp_ok));
        if (!exp_ok) chk(fail_addr == AW'(exp_fa), req, "fail address", 64'(fail_addr), 64'(exp_fa));
        chk(!hv_en && core_sel == 2'd0, "R9", "supplies at done", {hv_en, core_sel}, 64'd0);
        @(negedge clk);
        chk(!done && !busy && prog_ok == exp_ok, "R9", "held result",
            {done, busy, prog_ok}, {2'b00, exp_ok});
        chk(conflicts == 0, "R4", "bus contention cycles", 64'(conflicts), 64'd0);
        chk(bad_pulse == 0, "R2", "pulse outside program level", 64'(bad_pulse), 64'd0);
        if (seen_fall) chk(first_gap >= SUP, "R2", "supply settle before first pulse",
                           64'(first_gap), 64'(SUP));
    endtask

    initial begin
        int other;
        clear_model();
        repeat (3) @(negedge clk);
        // R1: idle outputs under reset
        chk({ce_n, oe_n, bus_drive, hv_en, core_sel, busy, done} == 8'b1100_0000,
            "R1", "outputs in reset", {ce_n, oe_n, bus_drive, hv_en, core_sel, busy, done}, 64'hC0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({ce_n, oe_n, bus_drive, hv_en, core_sel, busy, done} == 8'b1100_0000,
            "R1", "outputs idle after reset", {ce_n, oe_n, bus_drive, hv_en, core_sel, busy, done}, 64'hC0);

        // Full sweep: varied pulse needs, some words already matching
        clear_model();
        for (int a = 0; a < N; a++) begin
            tgt[a]  = ~((16'(a) * 16'h0123) | (16'h0001 << a));
            need[a] = (a % 5) + 1;
            if (a % 7 == 3) tgt[a] = 16'hFFFF;
        end
        run(0, N - 1, 0, 1'b1, 0, "R5");
        for (int a = 0; a < N; a++) begin
            if (mem0[a] == tgt[a])
                chk(pulses[a] == 0, "R6", "pulses on matching word", 64'(pulses[a]), 64'd0);
            else
                chk(pulses[a] == exp_pulses(a), "R5", "pulse count", 64'(pulses[a]), 64'(exp_pulses(a)));
            chk(mem[a] == tgt[a], "R5", "programmed word", 64'(mem[a]), 64'(tgt[a]));
        end
        chk(saw_hi && saw_lo, "R8", "both check levels visited", {saw_hi, saw_lo}, 64'h3);

        // Word needing a 0-to-1 change
        clear_model();
        for (int a = 2; a <= 9; a++) begin tgt[a] = 16'hF0F0 ^ 16'(a); need[a] = 2; end
        mem[6] = 16'h00FF; tgt[6] = 16'h0F0F;
        run(2, 9, 0, 1'b0, 6, "R7");
        chk(pulses[6] == 0, "R7", "no pulse on blocked word", 64'(pulses[6]), 64'd0);
        chk(mem[6] == 16'h00FF, "R7", "blocked word untouched", 64'(mem[6]), 64'h00FF);
        for (int a = 2; a <= 5; a++)
            chk(pulses[a] == exp_pulses(a), "R5", "pulses before blocked word", 64'(pulses[a]), 64'(exp_pulses(a)));
        chk(pulses[7] == 0 && !saw_hi, "R7", "stopped at blocked word", {pulses[7], saw_hi}, 64'd0);

        // Pulse budget exhausted
        clear_model();
        for (int a = 4; a <= 6; a++) tgt[a] = 16'h1234 + 16'(a);
        need[5] = 40;
        run(4, 6, 0, 1'b0, 5, "R5");
        chk(pulses[5] == MAXP, "R5", "pulses at budget limit", 64'(pulses[5]), 64'(MAXP));
        chk(mem[5] == 16'hFFFF, "R5", "unprogrammed word", 64'(mem[5]), 64'hFFFF);

        // Weak word failing only at the low check level
        clear_model();
        for (int a = 8; a <= 11; a++) begin tgt[a] = 16'h5A5A ^ 16'(a << 4); need[a] = 3; end
        drift[10] = 1;
        run(8, 11, 0, 1'b0, 10, "R8");
        chk(saw_hi && saw_lo, "R8", "failure after high-level pass", {saw_hi, saw_lo}, 64'h3);
        chk(mem[10] == tgt[10], "R8", "weak word was programmed", 64'(mem[10]), 64'(tgt[10]));

        // Reversed range
        clear_model();
        run(9, 3, 0, 1'b0, 9, "R11");
        chk(!hv_seen, "R11", "no supply request", 64'(hv_seen), 64'd0);

        // Single word with a start pulse while busy
        clear_model();
        tgt[12] = 16'hA5A5; need[12] = 3;
        tgt[0]  = 16'h0000;
        run(12, 12, 20, 1'b1, 0, "R10");
        chk(pulses[12] == 3, "R10", "single-word pulses", 64'(pulses[12]), 64'd3);
        other = 0;
        for (int a = 0; a < N; a++) if (a != 12) other += pulses[a];
        chk(other == 0 && mem[0] == 16'hFFFF, "R10", "second start ignored",
            {32'(other), mem[0]}, 64'h0000_0000_0000_FFFF);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule